// File: doc/BRIEF.md
# Windowed Run-Length Encoder

This block compresses a byte stream into (value, repeat count) pairs. One byte may arrive per clock, marked by an input strobe. The first byte after reset or after a flush becomes the reference. Each later byte either extends the current run or closes it. A run closes when a byte differs from the reference, or when the run already holds the largest allowed count. A closed run produces one pair on a registered output with its own strobe.

The block has no ready signal and no buffering. The consumer must take every pair in the cycle it appears. Pairs can appear on consecutive cycles when the input alternates on every byte. A flush strobe ends the stream: it emits the pending run and puts the block back into waiting for a new reference. The byte that closes a run is never lost. It becomes the reference of the next run with a count of one.

Top module: `rle_encoder`

## Requirements
- R1: The first valid byte after reset, or after a flush, is stored as the reference with a count of 1, and no pair is emitted for it.
- R2: A valid byte equal to the reference adds one to the run count and emits nothing, as long as the count is below the window limit.
- R3: A valid byte that differs from the reference emits the reference value and its count. That byte becomes the new reference with a count of 1.
- R4: The window limit is 32768 (parameter `WINDOW`). The count output is 16 bits wide and always carries a value from 1 to 32768. A matching byte that arrives while the count equals the limit emits (reference, 32768), and that byte starts a new run with a count of 1.
- R5: A flush while a run is pending emits that run and returns the block to waiting for a reference. A flush while waiting emits nothing.
- R6: In a cycle where flush is high, the input strobe and input byte are ignored.
- R7: `outValid` goes high in the cycle after the clock edge that sampled the closing byte or the flush, and it stays high for one cycle per pair. `outVal` and `outCnt` keep the last emitted pair until the next pair replaces it.
- R8: Reset clears `outValid`, `outVal` and `outCnt` to zero and puts the block into waiting for a reference.
- R9: A cycle with the input strobe low and flush low leaves the run unchanged, so a gap in the input does not split a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks `inByte` as valid in this cycle |
| inByte | input | 8 | Input stream byte |
| flush | input | 1 | End of stream: emit the pending run and wait for a new reference |
| outValid | output | 1 | One-cycle strobe for each emitted pair |
| outVal | output | 8 | Byte value of the emitted run |
| outCnt | output | 16 | Repeat count of the emitted run (1 to 32768) |

## Verification
A wrong reference shows up as a wrong `outVal` on the very next pair. A count that slips or wraps shows up in that pair's `outCnt`, exactly one clock after the closing byte. A state flag stuck on "waiting" suppresses the pair that the second distinct byte should produce. A flag stuck on "running" emits a spurious pair for the first byte after a flush. The longest hidden fault is a bad limit compare, which stays invisible until 32768 equal bytes have arrived. For that reason the window boundary is driven with its full length, and the byte after the boundary is checked for a count of one.

// File: rtl/rle_pkg.sv
package rle_pkg;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic capture;  // load reference from input byte, count := 1
    logic bump;     // count := count + 1
    logic emit;     // register (reference, count) onto the output
  } rleStrobe_t;

  typedef enum logic {
    WAIT_REF = 1'b0,
    COUNTING = 1'b1
  } rleState_t;

endpackage

// File: rtl/rle_ctrl.sv
module rle_ctrl
  import rle_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       flush,
  input  logic       match,
  input  logic       atLimit,
  output rleStrobe_t strobe,
  output logic       haveRef
);

  rleState_t state;
  rleState_t nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      WAIT_REF: begin
        // flush wins over the input strobe; nothing pending to emit
        if (!flush && inValid) begin
          strobe.capture = 1'b1;
          nextState      = COUNTING;
        end
      end
      COUNTING: begin
        if (flush) begin
          strobe.emit = 1'b1;
          nextState   = WAIT_REF;
        end else if (inValid) begin
          if (!match || atLimit) begin
            // close the run; the closing byte starts the next one
            strobe.emit    = 1'b1;
            strobe.capture = 1'b1;
          end else begin
            strobe.bump = 1'b1;
          end
        end
      end
      default: nextState = WAIT_REF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= WAIT_REF;
    else       state <= nextState;
  end

  assign haveRef = (state == COUNTING);

endmodule

// File: rtl/rle_datapath.sv
module rle_datapath
  import rle_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WINDOW = 32768,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inByte,
  input  rleStrobe_t        strobe,
  output logic              match,
  output logic              atLimit,
  output logic [DATA_W-1:0] refVal,
  output logic              outValid,
  output logic [DATA_W-1:0] outVal,
  output logic [CNT_W-1:0]  outCnt
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WINDOW);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] runCnt;

  assign match   = (inByte == refVal);
  assign atLimit = (runCnt == LIMIT);

  // Run state: reference byte and repeat count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refVal <= '0;
      runCnt <= '0;
    end else if (strobe.capture) begin
      refVal <= inByte;
      runCnt <= ONE;
    end else if (strobe.bump) begin
      runCnt <= runCnt + ONE;
    end
  end

  // Output register: loaded only on emit, held otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outVal   <= '0;
      outCnt   <= '0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.emit) begin
        outVal <= refVal;
        outCnt <= runCnt;
      end
    end
  end

endmodule

// File: rtl/rle_encoder.sv
module rle_encoder
  import rle_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WINDOW = 32768,
  localparam int CNT_W = $clog2(WINDOW + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inByte,
  input  logic              flush,
  output logic              outValid,
  output logic [DATA_W-1:0] outVal,
  output logic [CNT_W-1:0]  outCnt
);

  rleStrobe_t        strobe;
  logic              match;
  logic              atLimit;
  logic              haveRef;
  logic [DATA_W-1:0] refVal;

  rle_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .flush   (flush),
    .match   (match),
    .atLimit (atLimit),
    .strobe  (strobe),
    .haveRef (haveRef)
  );

  rle_datapath #(
    .DATA_W (DATA_W),
    .WINDOW (WINDOW),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inByte   (inByte),
    .strobe   (strobe),
    .match    (match),
    .atLimit  (atLimit),
    .refVal   (refVal),
    .outValid (outValid),
    .outVal   (outVal),
    .outCnt   (outCnt)
  );

endmodule

// File: rtl/rle_encoder_checker.sv
module rle_encoder_checker #(
  parameter int DATA_W = 8,
  parameter int WINDOW = 32768,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inByte,
  input logic              flush,
  input logic              outValid,
  input logic [DATA_W-1:0] outVal,
  input logic [CNT_W-1:0]  outCnt,
  input logic              haveRef,
  input logic [DATA_W-1:0] refVal
);

  // R1: with no reference held, nothing can be emitted next cycle
  a_r1_no_pair_without_ref: assert property (@(posedge clk) disable iff (!rstN)
    !haveRef |=> !outValid);

  // R3: a differing byte emits the old reference next cycle
  a_r3_mismatch_emits: assert property (@(posedge clk) disable iff (!rstN)
    (haveRef && inValid && !flush && inByte != refVal)
      |=> (outValid && outVal == $past(refVal) && haveRef));

  // R4: every emitted count lies inside the window
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outCnt >= CNT_W'(1) && outCnt <= CNT_W'(WINDOW)));

  // R5: flush with a pending run emits and drops the reference
  a_r5_flush_emits: assert property (@(posedge clk) disable iff (!rstN)
    (flush && haveRef) |=> (outValid && !haveRef));

  // R7: idle input leaves the output pair stable and the strobe low
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !flush) |=> (!outValid && $stable(outVal) && $stable(outCnt)));

  // R9: a gap keeps the run's reference
  a_r9_gap_keeps_run: assert property (@(posedge clk) disable iff (!rstN)
    (haveRef && !inValid && !flush) |=> (haveRef && $stable(refVal)));

endmodule

bind rle_encoder rle_encoder_checker #(
  .DATA_W (DATA_W),
  .WINDOW (WINDOW),
  .CNT_W  (CNT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inByte   (inByte),
  .flush    (flush),
  .outValid (outValid),
  .outVal   (outVal),
  .outCnt   (outCnt),
  .haveRef  (haveRef),
  .refVal   (refVal)
);

// File: tb/test_rle_encoder.sv
module test_rle_encoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = '0;
  logic        flush = 1'b0;
  logic        outValid;
  logic [7:0]  outVal;
  logic [15:0] outCnt;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  rle_encoder i_rle_encoder (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inByte   (inByte),
    .flush    (flush),
    .outValid (outValid),
    .outVal   (outVal),
    .outCnt   (outCnt)
  );

  // Vector: {valid, flush, byte, expValid, expVal, expCnt}; expectation holds
  // in the cycle after the edge that samples the inputs.
  localparam int NVEC = 17;
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'h41, 1'b0, 8'h00, 16'd0},  // R1 first byte is reference
    {1'b1, 1'b0, 8'h41, 1'b0, 8'h00, 16'd0},  // R2
    {1'b1, 1'b0, 8'h41, 1'b0, 8'h00, 16'd0},  // R2
    {1'b1, 1'b0, 8'h42, 1'b1, 8'h41, 16'd3},  // R3
    {1'b1, 1'b0, 8'h43, 1'b1, 8'h42, 16'd1},  // R3 new ref count 1
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h42, 16'd1},  // R9 gap, R7 hold
    {1'b1, 1'b0, 8'h43, 1'b0, 8'h42, 16'd1},  // R9
    {1'b1, 1'b0, 8'h43, 1'b0, 8'h42, 16'd1},
    {1'b1, 1'b0, 8'h44, 1'b1, 8'h43, 16'd3},  // R9 run spanned gap
    {1'b0, 1'b1, 8'h00, 1'b1, 8'h44, 16'd1},  // R5 flush
    {1'b1, 1'b0, 8'h45, 1'b0, 8'h44, 16'd1},  // R1 after flush
    {1'b1, 1'b0, 8'h45, 1'b0, 8'h44, 16'd1},
    {1'b1, 1'b1, 8'h46, 1'b1, 8'h45, 16'd2},  // R6 byte ignored under flush
    {1'b0, 1'b1, 8'h00, 1'b0, 8'h45, 16'd2},  // R5 flush while waiting
    {1'b1, 1'b0, 8'h00, 1'b0, 8'h45, 16'd2},  // R6 no ref was taken from 46
    {1'b1, 1'b0, 8'hFF, 1'b1, 8'h00, 16'd1},  // R3
    {1'b0, 1'b1, 8'h00, 1'b1, 8'hFF, 16'd1}   // R5
  };

  task automatic printSummary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic checkOut(string req, logic expV, logic [7:0] expVal, logic [15:0] expCnt);
    compared++;
    if (outValid !== expV || outVal !== expVal || outCnt !== expCnt) begin
      mismatched++;
      $display("FAIL %s: got valid=%0b val=%h cnt=%0d, expected valid=%0b val=%h cnt=%0d",
               req, outValid, outVal, outCnt, expV, expVal, expCnt);
    end
  endtask

  // Drive at a falling edge, let one rising edge sample, return at falling edge
  task automatic step(logic v, logic f, logic [7:0] b);
    inValid = v;
    flush   = f;
    inByte  = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got %0d cycles, expected under 150000", cycles);
      printSummary();
      $finish;
    end
  end

  initial begin
    int early;
    @(negedge clk);
    @(negedge clk);
    checkOut("R8 reset state", 1'b0, 8'h00, 16'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector walk
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][34], VEC[i][33], VEC[i][32:25]);
      checkOut($sformatf("R1-R9 vector %0d", i), VEC[i][24], VEC[i][23:16], VEC[i][15:0]);
    end

    // Window limit: R4
    step(1'b0, 1'b1, 8'h00);  // clear anything pending
    early = 0;
    for (int i = 0; i < 32768; i++) begin
      step(1'b1, 1'b0, 8'h55);
      if (outValid) early++;
    end
    compared++;
    if (early != 0) begin
      mismatched++;
      $display("FAIL R4 premature pair: got %0d pairs, expected 0", early);
    end
    step(1'b1, 1'b0, 8'h55);
    checkOut("R4 limit close", 1'b1, 8'h55, 16'd32768);
    step(1'b1, 1'b0, 8'h66);
    checkOut("R4 carried byte count 1", 1'b1, 8'h55, 16'd1);
    step(1'b0, 1'b1, 8'h00);
    checkOut("R5 flush after limit", 1'b1, 8'h66, 16'd1);

    // Reset mid-run: R8 then R1
    step(1'b1, 1'b0, 8'h10);
    step(1'b1, 1'b0, 8'h10);
    rstN = 1'b0;
    inValid = 1'b0;
    #1;
    checkOut("R8 mid-run reset", 1'b0, 8'h00, 16'd0);
    @(negedge clk);
    rstN = 1'b1;
    step(1'b1, 1'b0, 8'h20);
    checkOut("R1 first byte after reset", 1'b0, 8'h00, 16'd0);
    step(1'b1, 1'b0, 8'h21);
    checkOut("R3 after reset", 1'b1, 8'h20, 16'd1);
    step(1'b0, 1'b0, 8'h00);
    checkOut("R7 strobe one cycle", 1'b0, 8'h20, 16'd1);

    done = 1'b1;
    printSummary();
    $finish;
  end

endmodule